// File: doc/BRIEF.md
# Quad Prescaled Reference Timer

This block holds four 16-bit up-counters. Each one advances on a tick taken from its own prescale chain. The chain is an 8-bit primary divider, an optional fixed divide-by-16 stage and an 8-bit secondary divider, all in series. Each counter is compared with a reference value. When the counter equals the reference on a tick, the timer latches an event bit. That event either sends the counter back to zero or lets it keep counting up. The event, gated by an enable in the mode word, drives a level interrupt line per timer.

Software sets up each timer through a small synchronous bus:
- Writes take effect on the clock edge and honour two byte enables.
- Reads are combinational from the address.

The timers come in pairs. A shared control byte per pair carries a stop bit and a reset bit for each timer of that pair. Software normally does the following:
1. Holds the timer in reset.
2. Programs the mode word, the primary divider and the reference.
3. Clears any pending events.
4. Releases the control bits.

Top module: `ptmr_quad`

## Requirements
- R1: A timer with clock source 1 ticks once every (P+1)*(S+1) clocks, and one with clock source 2 ticks once every 16*(P+1)*(S+1) clocks. P is the primary divider (bits 7:0 of the timer's divider word) and S is the secondary divider. Both dividers start their count when the timer leaves reset.
- R2: Mode word fields:
  - Bits 2:1 select the clock source. Value 1 is the plain clock, value 2 is the clock divided by 16, and values 0 and 3 give no ticks, so the counter stays put.
  - Bit 3 is the restart bit.
  - Bit 4 is the interrupt enable.
  - Bits 15:8 hold the secondary divider S.
- R3: With the restart bit set, a tick while the counter equals the reference loads zero and sets the event. The counter therefore runs 0..ref.
- R4: With the restart bit clear, the counter keeps incrementing past the reference and wraps from 0xFFFF to 0x0000. The event is set on the tick where the counter equals the reference.
- R5: The event word reports the reference event in bit 1, and its other bits read zero. Writing a 1 to bit 1 clears the event, and writing 0 leaves it alone. A hardware set in the same cycle as a clearing write wins.
- R6: A timer's interrupt is high exactly while its event bit is set and its mode bit 4 is set.
- R7: Control byte k serves timers 2k and 2k+1. The even timer uses bit 1 as stop and bit 0 as reset. The odd timer uses bit 5 as stop and bit 4 as reset. One timer's bits never affect the other timer.
- R8: While a timer's stop bit is set and its reset bit is clear, its counter and divider state hold their values.
- R9: While a timer's reset bit is set, its counter, divider state and event are forced to zero, and counter writes are overridden.
- R10: A bus write to a counter loads it on that edge and takes priority over a tick.
- R11: Address map, in 16-bit word addresses:
  - Words 0 and 1 are control bytes 0 and 1, held in the low byte.
  - Timer t occupies words 8+8t to 15+8t. Offset 0 is the mode word, 1 the reference, 2 the capture, 3 the counter, 4 the event word and 5 the primary divider.
  - Every other address reads zero.
  - be_i[0] enables bits 7:0 of a write and be_i[1] enables bits 15:8.
- R12: After rst_ni is asserted, every register, counter, event and interrupt is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables for the write |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| irq_o | output | 4 | Interrupt, one per timer |

## Verification
The checks on counter motion and events are conditioned on the timer's own reset and stop bits, and they exclude cycles that carry a counter write. They also take for granted that the divider words and the secondary field change only while a timer is held in reset. Without that, a divider could sit above its new limit and wrap through 256. The stimulus reprograms every timer only between setting and releasing its reset bit. Counter preloads are made with the stop bit set and the reset bit released. The only bus traffic during counting is one event clear, placed on purpose on a match edge.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned DW = 16;

  typedef enum logic [1:0] {
    SRC_CHAIN = 2'd0,
    SRC_CLK   = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;

  typedef struct packed {
    logic [7:0] sec_div;
    logic [2:0] rsv_hi;
    logic       irq_en;
    logic       restart;
    logic [1:0] src;
    logic       rsv_lo;
  } mode_t;

  // control byte bit positions per half of a pair
  localparam int unsigned RST_EVEN  = 0;
  localparam int unsigned STP_EVEN  = 1;
  localparam int unsigned RST_ODD   = 4;
  localparam int unsigned STP_ODD   = 5;
  localparam int unsigned EVT_REF   = 1;

  // word offsets inside a timer window
  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_REF  = 3'd1;
  localparam logic [2:0] OFS_CAP  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd3;
  localparam logic [2:0] OFS_EVT  = 3'd4;
  localparam logic [2:0] OFS_PSR  = 3'd5;

  function automatic logic [DW-1:0] merge_be(logic [DW-1:0] old_v,
                                             logic [DW-1:0] new_v,
                                             logic [1:0]    be);
    merge_be = old_v;
    if (be[0]) merge_be[7:0]  = new_v[7:0];
    if (be[1]) merge_be[15:8] = new_v[15:8];
  endfunction
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale
  import ptmr_pkg::*;
#(
  parameter int unsigned PW  = 8,
  parameter int unsigned SW  = 8,
  parameter int unsigned DIV = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [1:0]    src_i,
  input  logic [PW-1:0] psr_i,
  input  logic [SW-1:0] sps_i,
  output logic          tick_o
);
  localparam int unsigned FW = $clog2(DIV);

  logic [PW-1:0] p_q;
  logic [FW-1:0] f_q;
  logic [SW-1:0] s_q;
  logic          en, p_done, f_done, s_done, use_f;

  assign use_f  = (src_i == SRC_DIV16);
  assign en     = run_i && (src_i == SRC_CLK || use_f);
  assign p_done = (p_q == psr_i);
  assign f_done = !use_f || (f_q == FW'(DIV - 1));
  assign s_done = (s_q == sps_i);
  assign tick_o = en && p_done && f_done && s_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q <= '0;
      f_q <= '0;
      s_q <= '0;
    end else if (clr_i) begin
      p_q <= '0;
      f_q <= '0;
      s_q <= '0;
    end else if (en) begin
      if (p_done) begin
        p_q <= '0;
        if (use_f) f_q <= f_done ? '0 : f_q + 1'b1;
        if (f_done) s_q <= s_done ? '0 : s_q + 1'b1;
      end else begin
        p_q <= p_q + 1'b1;
      end
    end
  end

  a_r9_div_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (p_q == '0 && f_q == '0 && s_q == '0));
  a_r8_div_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> ($stable(p_q) && $stable(s_q) && $stable(f_q)));
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] ref_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wd_i,
  input  logic          evt_clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          evt_o
);
  logic [CW-1:0] cnt_q;
  logic          evt_q, match;

  assign match = tick_i && (cnt_q == ref_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      if (cnt_we_i)                cnt_q <= cnt_wd_i;
      else if (match && restart_i) cnt_q <= '0;
      else if (tick_i)             cnt_q <= cnt_q + 1'b1;
      // hardware set wins over write-one-to-clear
      if (match)          evt_q <= 1'b1;
      else if (evt_clr_i) evt_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign evt_o = evt_q;

  a_r9_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !evt_q));
  a_r3_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && restart_i && !cnt_we_i && !clr_i) |=> (cnt_q == '0));
  a_r4_free_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(match && restart_i) && !cnt_we_i && !clr_i)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && !clr_i) |=> evt_q);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/ptmr_quad.sv
module ptmr_quad
  import ptmr_pkg::*;
#(
  parameter int unsigned NT = 4,
  parameter int unsigned AW = 6,
  parameter int unsigned PW = 8,
  parameter int unsigned SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic [1:0]    be_i,
  input  logic          we_i,
  output logic [15:0]   rdata_o,
  output logic [NT-1:0] irq_o
);
  localparam int unsigned NP    = NT / 2;
  localparam int unsigned PIW   = (NP > 1) ? $clog2(NP) : 1;
  localparam int unsigned TIW   = (NT > 1) ? $clog2(NT) : 1;
  localparam int unsigned TBASE = 8;

  logic [AW-1:0]   off;
  logic [AW-4:0]   tsel;
  logic [TIW-1:0]  tidx;
  logic [2:0]      rsel;
  logic            in_tmr, in_cfg;

  assign off    = addr_i - TBASE[AW-1:0];
  assign tsel   = off[AW-1:3];
  assign tidx   = tsel[TIW-1:0];
  assign rsel   = off[2:0];
  assign in_tmr = (addr_i >= TBASE[AW-1:0]) && (int'(tsel) < NT);
  assign in_cfg = (int'(addr_i) < NP);

  logic [7:0]    cfg_rd  [NP];
  logic [15:0]   mode_rd [NT];
  logic [15:0]   ref_rd  [NT];
  logic [15:0]   cap_rd  [NT];
  logic [15:0]   cnt_rd  [NT];
  logic [15:0]   psr_rd  [NT];
  logic [NT-1:0] evt;

  for (genvar p = 0; p < NP; p++) begin : g_pair
    logic [7:0] cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else if (we_i && in_cfg && be_i[0] && int'(addr_i) == p) cfg_q <= wdata_i[7:0];
    end
    assign cfg_rd[p] = cfg_q;
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    localparam int unsigned STP = (t % 2) ? STP_ODD : STP_EVEN;
    localparam int unsigned RST = (t % 2) ? RST_ODD : RST_EVEN;
    mode_t         mode_q;
    logic [15:0]   ref_q, cap_q;
    logic [PW-1:0] psr_q;
    logic [15:0]   cnt;
    logic [15:0]   psr_wd;
    logic          hit, clr, run, tick;

    assign hit    = we_i && in_tmr && (tidx == t);
    assign clr    = cfg_rd[t/2][RST];
    assign run    = !cfg_rd[t/2][STP];
    assign psr_wd = merge_be(16'(psr_q), wdata_i, be_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= '0;
        ref_q  <= '0;
        cap_q  <= '0;
        psr_q  <= '0;
      end else if (hit) begin
        if (rsel == OFS_MODE) mode_q <= merge_be(mode_q, wdata_i, be_i);
        if (rsel == OFS_REF)  ref_q  <= merge_be(ref_q, wdata_i, be_i);
        if (rsel == OFS_CAP)  cap_q  <= merge_be(cap_q, wdata_i, be_i);
        if (rsel == OFS_PSR)  psr_q  <= psr_wd[PW-1:0];
      end
    end

    ptmr_prescale #(.PW(PW), .SW(SW)) i_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .run_i  (run),
      .src_i  (mode_q.src),
      .psr_i  (psr_q),
      .sps_i  (mode_q.sec_div[SW-1:0]),
      .tick_o (tick)
    );

    ptmr_channel #(.CW(16)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .tick_i    (tick),
      .restart_i (mode_q.restart),
      .ref_i     (ref_q),
      .cnt_we_i  (hit && rsel == OFS_CNT),
      .cnt_wd_i  (merge_be(cnt, wdata_i, be_i)),
      .evt_clr_i (hit && rsel == OFS_EVT && be_i[0] && wdata_i[EVT_REF]),
      .cnt_o     (cnt),
      .evt_o     (evt[t])
    );

    assign irq_o[t]   = evt[t] && mode_q.irq_en;
    assign mode_rd[t] = mode_q;
    assign ref_rd[t]  = ref_q;
    assign cap_rd[t]  = cap_q;
    assign cnt_rd[t]  = cnt;
    assign psr_rd[t]  = 16'(psr_q);

    a_r6_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o[t] && !clr && !hit) |=> irq_o[t]);
  end

  always_comb begin
    rdata_o = '0;
    if (in_cfg) begin
      rdata_o = {8'h00, cfg_rd[addr_i[PIW-1:0]]};
    end else if (in_tmr) begin
      unique case (rsel)
        OFS_MODE: rdata_o = mode_rd[tidx];
        OFS_REF:  rdata_o = ref_rd[tidx];
        OFS_CAP:  rdata_o = cap_rd[tidx];
        OFS_CNT:  rdata_o = cnt_rd[tidx];
        OFS_EVT:  rdata_o = 16'(evt[tidx]) << EVT_REF;
        OFS_PSR:  rdata_o = psr_rd[tidx];
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: tb/test_ptmr_quad.sv
module test_ptmr_quad;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [1:0]  be_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] rdata_o;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;

  ptmr_quad i_ptmr_quad (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .be_i(be_i), .we_i(we_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #10 clk_i = ~clk_i;

  // psr, sps, src, ref, restart, cycles
  localparam int VEC [6][6] = '{
    '{0, 0, 1, 10,  1, 25},
    '{1, 2, 1, 100, 0, 60},
    '{0, 0, 2, 3,   1, 70},
    '{3, 0, 1, 2,   0, 40},
    '{0, 1, 2, 50,  0, 33},
    '{2, 1, 1, 1,   1, 50}
  };

  function automatic int a_t(int t, int r);
    return 8 + t * 8 + r;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d, logic [1:0] be = 2'b11);
    addr_i = 6'(a); wdata_i = d; be_i = be; we_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b0; be_i = '0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    addr_i = 6'(a);
    #2;
    d = rdata_o;
  endtask

  task automatic cfg_bits(int t, bit stp, bit rst, output logic [7:0] b);
    b = '0;
    if (t % 2 == 0) begin b[1] = stp; b[0] = rst; end
    else            begin b[5] = stp; b[4] = rst; end
  endtask

  task automatic setup(int t, int psr, int sps, int src, int rf, int rs, int ori);
    logic [7:0] b;
    cfg_bits(t, 1'b1, 1'b1, b);
    wr(t / 2, {8'h00, b});
    wr(a_t(t, 0), 16'((sps << 8) | (ori << 4) | (rs << 3) | (src << 1)));
    wr(a_t(t, 5), 16'(psr));
    wr(a_t(t, 1), 16'(rf));
    wr(a_t(t, 4), 16'hFFFF);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, d0, d1, e0, e1;
    logic [7:0]  b;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R12 reset state
    rd(0, d);            chk("R12 cfg0", d, 16'h0);
    rd(a_t(0, 0), d);    chk("R12 mode0", d, 16'h0);
    rd(a_t(3, 3), d);    chk("R12 cnt3", d, 16'h0);
    chk("R12 irq", 16'(irq_o), 16'h0);

    // R11 reserved words
    rd(2, d);            chk("R11 reserved 2", d, 16'h0);
    rd(a_t(1, 6), d);    chk("R11 reserved t1+6", d, 16'h0);
    rd(50, d);           chk("R11 reserved 50", d, 16'h0);

    // R1 R2 R3 R4 R6: vector walk
    for (int i = 0; i < 6; i++) begin
      int t, p, tt, ce, ev;
      t = i % 4;
      p = (VEC[i][0] + 1) * (VEC[i][1] + 1) * ((VEC[i][2] == 2) ? 16 : 1);
      tt = VEC[i][5] / p;
      if (VEC[i][4] != 0) begin ce = tt % (VEC[i][3] + 1); ev = (tt >= VEC[i][3] + 1) ? 1 : 0; end
      else                begin ce = tt % 65536;           ev = (tt > VEC[i][3]) ? 1 : 0; end
      setup(t, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1);
      wr(t / 2, 16'h0);
      repeat (VEC[i][5]) @(negedge clk_i);
      rd(a_t(t, 3), d);  chk("R1 R3 R4 count", d, 16'(ce));
      rd(a_t(t, 4), d);  chk("R5 event bit", d, 16'(ev << 1));
      chk("R6 irq", 16'(irq_o[t]), 16'(ev));
      wr(t / 2, 16'h0033);
    end

    // R5 write-one-to-clear and write-zero
    setup(0, 0, 0, 1, 2, 1, 1);
    wr(0, 16'h0);
    repeat (10) @(negedge clk_i);
    wr(0, 16'h0002);                       // stop timer0
    wr(a_t(0, 4), 16'h0000);
    rd(a_t(0, 4), d);  chk("R5 write zero keeps", d, 16'h0002);
    wr(a_t(0, 4), 16'h0002);
    rd(a_t(0, 4), d);  chk("R5 w1c clears", d, 16'h0000);
    chk("R6 irq low after clear", 16'(irq_o[0]), 16'h0);

    // R8 stop holds
    rd(a_t(0, 3), d0);
    repeat (10) @(negedge clk_i);
    rd(a_t(0, 3), d);  chk("R8 stopped holds", d, d0);

    // R10 counter load, R11 byte enable
    wr(a_t(0, 3), 16'h1234);
    rd(a_t(0, 3), d);  chk("R10 load", d, 16'h1234);
    wr(a_t(0, 3), 16'hAB00, 2'b10);
    rd(a_t(0, 3), d);  chk("R11 upper byte only", d, 16'hAB34);

    // R9 reset bit forces zero and overrides a counter write
    wr(0, 16'h0003);
    wr(a_t(0, 3), 16'h5555);
    rd(a_t(0, 3), d);  chk("R9 cnt forced zero", d, 16'h0);
    rd(a_t(0, 4), d);  chk("R9 evt forced zero", d, 16'h0);

    // R4 wrap past 0xFFFF then through reference
    setup(0, 0, 0, 1, 5, 0, 1);
    wr(0, 16'h0002);                       // released from reset, stopped
    wr(a_t(0, 3), 16'hFFFE);
    wr(0, 16'h0000);
    repeat (3) @(negedge clk_i);
    rd(a_t(0, 3), d);  chk("R4 wrap", d, 16'h0001);
    rd(a_t(0, 4), d);  chk("R4 no event yet", d, 16'h0000);
    repeat (5) @(negedge clk_i);
    rd(a_t(0, 3), d);  chk("R4 passes ref", d, 16'h0006);
    rd(a_t(0, 4), d);  chk("R4 event at ref", d, 16'h0002);

    // R7 pair independence
    setup(0, 0, 0, 1, 16'hFFFF, 0, 0);
    setup(1, 0, 0, 1, 16'hFFFF, 0, 0);
    wr(0, 16'h0000);
    wr(0, 16'h0020);                       // stop odd timer only
    rd(a_t(0, 3), d0); rd(a_t(1, 3), d1);
    repeat (10) @(negedge clk_i);
    rd(a_t(0, 3), e0); rd(a_t(1, 3), e1);
    chk("R7 even runs", e0, d0 + 16'd10);
    chk("R7 odd stopped", e1, d1);
    wr(0, 16'h0002);                       // stop even timer only
    rd(a_t(0, 3), d0); rd(a_t(1, 3), d1);
    repeat (7) @(negedge clk_i);
    rd(a_t(0, 3), e0); rd(a_t(1, 3), e1);
    chk("R7 even stopped", e0, d0);
    chk("R7 odd runs", e1, d1 + 16'd7);

    // R2 source 0 gives no ticks
    setup(2, 0, 0, 0, 2, 1, 1);
    wr(1, 16'h0);
    repeat (20) @(negedge clk_i);
    rd(a_t(2, 3), d);  chk("R2 source 0 idle", d, 16'h0);

    // R6 enable off masks interrupt
    setup(3, 0, 0, 1, 2, 1, 0);
    wr(1, 16'h0);
    repeat (10) @(negedge clk_i);
    rd(a_t(3, 4), d);  chk("R6 event set", d, 16'h0002);
    chk("R6 irq masked", 16'(irq_o[3]), 16'h0);

    // R5 hardware set beats a clearing write on the same edge
    setup(2, 0, 0, 1, 4, 1, 1);
    cfg_bits(3, 1'b1, 1'b1, b);
    wr(1, {8'h00, b});                     // timer2 runs, timer3 held
    repeat (9) @(negedge clk_i);
    wr(a_t(2, 4), 16'hFFFF);               // lands on the second match edge
    rd(a_t(2, 4), d);  chk("R5 set wins", d, 16'h0002);
    wr(a_t(2, 4), 16'hFFFF);
    rd(a_t(2, 4), d);  chk("R5 clear after", d, 16'h0000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule